// File: doc/BRIEF.md
# DS3 Transmit Frame Reference Generator

This block provides reference timing for a bit-serial DS3 payload source. It runs on a single 44.736 MHz clock and passes that clock through as its output clock. It walks continuously through the DS3 M-frame. An M-frame has seven subframes. Each subframe has eight blocks of 85 bits. The frame is therefore 4760 bit times long and holds 56 overhead positions.

The block drives three timing outputs, all aligned to the bit being sent. The first is an active-low strobe on bit 1 of the M-frame. The second is an active-low gap strobe on the first bit of each 85-bit block. The third is a reference data line. On that line only the framing bits (F) and the multiframe bits (M) carry their required values. Every other position is held at 0.

A downstream payload source uses the gap strobe to leave the overhead slots free. It uses the frame strobe to align itself to the multiframe. A synchronous active-high reset returns the position to bit 1 of the M-frame.

Top module: `ds3_frame_ref_gen`

## Requirements
- R1: In the first clock after reset is released, the block presents bit 1 of the M-frame: frame_n=0, gap_n=0 and ref_data=0.
- R2: frame_n is low for exactly one clock every 4760 clocks, on bit 1 of the M-frame, and is high at all other times.
- R3: gap_n is low for one clock on bit 1 of each 85-bit block, which gives 56 low pulses per M-frame. Bit 1 of block b in subframe s falls at frame offset 680*s + 85*b, with s and b counting from 0.
- R4: The F overhead positions are blocks 1, 3, 5 and 7 of every subframe. On these positions ref_data carries 1, 0, 0 and 1 in that order.
- R5: Block 0 of each subframe is the X/P/M position. In subframes 5, 6 and 7 (counting from 1) it carries the M-bits 0, 1, 0, so ref_data is 1 only in subframe 6. In subframes 1 to 4 it carries 0.
- R6: The C overhead positions (blocks 2, 4 and 6) and all 84 payload bits of each block drive ref_data=0.
- R7: ref_clk is the input clock passed straight through, so it is low while clk is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 44.736 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset to bit 1 of the M-frame |
| ref_clk | output | 1 | Output clock, the input clock passed through |
| frame_n | output | 1 | Active-low strobe on bit 1 of the M-frame |
| gap_n | output | 1 | Active-low strobe on each overhead bit position |
| ref_data | output | 1 | Reference data: F and M values, 0 elsewhere |

## Verification
The generator is run freely for two whole M-frames from reset. This shows that the counters roll over correctly at the end of a block, at the end of a subframe and at the end of the frame, rather than only once. It is then reset about 1000 bits into a frame and run for one more frame. That shows the restart lands on bit 1 and not on some intermediate position. Every bit is compared against a position model. A separate measurement of the interval between frame strobes and of the number of gap pulses between them distinguishes a wrong period from a wrong value at a single position.

// File: rtl/ds3rg_pkg.sv
package ds3rg_pkg;

    localparam int BLOCK_BITS     = 85;
    localparam int BLOCKS_PER_SUB = 8;
    localparam int SUBFRAMES      = 7;
    localparam int FRAME_BITS     = BLOCK_BITS * BLOCKS_PER_SUB * SUBFRAMES;
    localparam int BIT_W          = $clog2(BLOCK_BITS);
    localparam int BLK_W          = $clog2(BLOCKS_PER_SUB);
    localparam int SUB_W          = $clog2(SUBFRAMES);

    // Subframe index that carries the M-bit set to 1 (0-based: subframe 6 of 7)
    localparam int M_ONE_SUB      = 5;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bitpos;
    } pos_t;

    typedef enum logic [1:0] {
        OH_XPM,
        OH_F,
        OH_C
    } oh_kind_t;

    function automatic oh_kind_t kind_of(input logic [BLK_W-1:0] blk);
        if (blk == '0)       return OH_XPM;
        else if (blk[0])     return OH_F;
        else                 return OH_C;
    endfunction

    // F-bit pattern 1,0,0,1 across blocks 1,3,5,7
    function automatic logic f_value(input logic [BLK_W-1:0] blk);
        logic [1:0] idx;
        idx = 2'(blk >> 1);
        return (idx == 2'd0) || (idx == 2'd3);
    endfunction

    // M-bits 0,1,0 in the last three subframes; X/P slots carry 0 here
    function automatic logic m_value(input logic [SUB_W-1:0] sub);
        return sub == SUB_W'(M_ONE_SUB);
    endfunction

endpackage

// File: rtl/ds3rg_modctr.sv
module ds3rg_modctr #(
    parameter int MOD = 85,
    localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] value,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    assign at_last = (value == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (en)
            value <= at_last ? '0 : value + 1'b1;
    end

    // R3: count never leaves its modulus range
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        value <= LAST);

    // R3: wrap back to the first position after the last
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && at_last) |=> (value == '0));

endmodule

// File: rtl/ds3rg_encode.sv
module ds3rg_encode
    import ds3rg_pkg::*;
(
    input  pos_t pos,
    output logic frame_n,
    output logic gap_n,
    output logic ref_data
);
    oh_kind_t kind;
    logic     is_oh;

    always_comb begin
        is_oh = (pos.bitpos == '0);
        kind  = kind_of(pos.blk);
        gap_n = ~is_oh;
        frame_n = ~(is_oh && pos.blk == '0 && pos.sub == '0);
        ref_data = 1'b0;
        if (is_oh) begin
            unique case (kind)
                OH_XPM:  ref_data = m_value(pos.sub);
                OH_F:    ref_data = f_value(pos.blk);
                default: ref_data = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ds3_frame_ref_gen.sv
module ds3_frame_ref_gen
    import ds3rg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic ref_clk,
    output logic frame_n,
    output logic gap_n,
    output logic ref_data
);
    pos_t pos;
    logic bit_last, blk_last, sub_last;

    assign ref_clk = clk;

    ds3rg_modctr #(.MOD(BLOCK_BITS)) u_bit (
        .clk(clk), .rst(rst), .en(1'b1),
        .value(pos.bitpos), .at_last(bit_last)
    );

    ds3rg_modctr #(.MOD(BLOCKS_PER_SUB)) u_blk (
        .clk(clk), .rst(rst), .en(bit_last),
        .value(pos.blk), .at_last(blk_last)
    );

    ds3rg_modctr #(.MOD(SUBFRAMES)) u_sub (
        .clk(clk), .rst(rst), .en(bit_last && blk_last),
        .value(pos.sub), .at_last(sub_last)
    );

    ds3rg_encode u_enc (
        .pos(pos), .frame_n(frame_n), .gap_n(gap_n), .ref_data(ref_data)
    );

    // R2: frame strobe only on an overhead slot
    a_r2_frame_on_gap: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> !gap_n);

    // R2: frame strobe lasts one clock
    a_r2_one_wide: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> frame_n);

    // R3: gap strobe lasts one clock
    a_r3_gap_one_wide: assert property (@(posedge clk) disable iff (rst)
        !gap_n |=> gap_n);

    // R6: data is 1 only in overhead slots
    a_r6_data_only_overhead: assert property (@(posedge clk) disable iff (rst)
        ref_data |-> !gap_n);

    // R2: the last bit of the frame is followed by the frame strobe
    a_r2_frame_after_last: assert property (@(posedge clk) disable iff (rst)
        (bit_last && blk_last && sub_last) |=> !frame_n);

endmodule

// File: tb/ds3_frame_ref_gen_bench.sv
module ds3_frame_ref_gen_bench;
    localparam int FRAME = 4760;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk, frame_n, gap_n, ref_data;

    int total = 0;
    int bad   = 0;
    bit mon_on = 0;
    bit done   = 0;

    typedef struct packed {
        logic        f;
        logic        g;
        logic        d;
        logic [31:0] idx;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    ds3_frame_ref_gen u_ds3_frame_ref_gen (
        .clk(clk), .rst(rst), .ref_clk(ref_clk),
        .frame_n(frame_n), .gap_n(gap_n), .ref_data(ref_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v, input int idx);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at offset %0d: actual=%0d expected=%0d", req, idx, act, exp_v);
        end
    endtask

    task automatic push_frames(input int n);
        for (int i = 0; i < n * FRAME; i++) begin
            exp_t e;
            int o, s, b, p;
            o = i % FRAME;
            s = o / 680;
            b = (o % 680) / 85;
            p = o % 85;
            e.idx = 32'(i);
            e.f = !(o == 0);
            e.g = !(p == 0);
            e.d = (p == 0) && (b == 1 || b == 7 || (b == 0 && s == 5));
            q.push_back(e);
        end
    endtask

    int last_frame = -1;
    int gaps = 0;

    always @(negedge clk) begin
        check(ref_clk == 1'b0, "R7", int'(ref_clk), 0, -1);
        if (mon_on && q.size() > 0) begin
            exp_t e;
            int o, b, p;
            string dreq;
            e = q.pop_front();
            o = int'(e.idx) % FRAME;
            b = (o % 680) / 85;
            p = o % 85;
            if (e.idx == 0) begin
                check(frame_n == 1'b0 && gap_n == 1'b0 && ref_data == 1'b0, "R1",
                      {frame_n, gap_n, ref_data}, 0, 0);
                last_frame = -1;
                gaps = 0;
            end
            check(frame_n == e.f, "R2", int'(frame_n), int'(e.f), int'(e.idx));
            check(gap_n == e.g, "R3", int'(gap_n), int'(e.g), int'(e.idx));
            if (p != 0)                     dreq = "R6";
            else if (b == 0)                dreq = "R5";
            else if (b % 2 == 1)            dreq = "R4";
            else                            dreq = "R6";
            check(ref_data == e.d, dreq, int'(ref_data), int'(e.d), int'(e.idx));
            if (!frame_n) begin
                if (last_frame >= 0) begin
                    check(int'(e.idx) - last_frame == FRAME, "R2 period",
                          int'(e.idx) - last_frame, FRAME, int'(e.idx));
                    check(gaps == 56, "R3 count", gaps, 56, int'(e.idx));
                end
                last_frame = int'(e.idx);
                gaps = 0;
            end
            if (!gap_n) gaps++;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        push_frames(2);
        #1 rst = 1'b0;
        mon_on = 1;
        wait (q.size() == 0);
        // R1: restart from a mid-frame position
        @(posedge clk);
        repeat (1000) @(posedge clk);
        #1 rst = 1'b1;
        mon_on = 0;
        @(posedge clk);
        @(posedge clk);
        #1;
        q.delete();
        push_frames(1);
        push_frames(0);
        rst = 1'b0;
        mon_on = 1;
        wait (q.size() == 0);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule